// File: doc/BRIEF.md
# Set-Associative Data Address Translation Buffer

This block turns a data virtual address into a physical address by looking it up in a small set-associative translation buffer. Each set holds up to `NUM_WAYS` entries. Every entry has a tag half and an attribute half. The tag half stores a virtual tag, a valid flag and an age counter used for replacement. The attribute half stores a physical page number, a cache-inhibit flag and four access-enable flags: read and write, each for supervisor mode and for user mode. The lookup is combinational. The age counters change on the clock edge that follows a qualified hit.

When translation is switched off, or the unit is configured as absent, the address passes straight through. In that case a fixed rule on the top address bit decides whether the access is cache-inhibited. When translation is on, a lookup yields one of three results: a translated address, a one-cycle page-fault pulse when the access rights forbid the access, or a one-cycle miss pulse with a zero address. Refill on a miss is left to software, which loads entries through a register-style write port. A second, read-only lookup port serves debug. It never raises a fault or a miss and never ages entries. A constant configuration word reports the geometry of the buffer.

Top module: `dtlb_lookup`

## Requirements
- R1: When `xlate_en_i` or `mmu_present_i` is low, `pa_o` equals `va_i`, `ci_o` equals 1 exactly when `va_i >= 32'h8000_0000`, `hit_o` is 0, and neither `page_fault_o` nor `tlb_miss_o` pulses.
- R2: With translation active, the set is `va_i[PAGE_W +: SET_W]` and the tag is `va_i[VA_W-1 -: TAG_W]`. A way hits only if its stored tag equals this tag and its valid flag is set.
- R3: On a hit, `hit_o` is 1, `pa_o` is `{ppn, va_i[PAGE_W-1:0]}`, and `ci_o` is the hitting entry's cache-inhibit bit (attribute bit 0).
- R4: Attribute bits are: 1 supervisor read, 2 supervisor write, 3 user read, 4 user write. On a hit, the bit for the current mode (`super_i`) and direction (`we_i`) must be 1. Otherwise `page_fault_o` pulses in every cycle where `req_valid_i` is 1.
- R5: With translation active and no hitting way, `pa_o` is 0, `ci_o` and `hit_o` are 0, and `tlb_miss_o` is 1 in every cycle where `req_valid_i` is 1. No strobe pulses while `req_valid_i` is 0.
- R6: At the clock edge of a hit with `req_valid_i` set, the hitting way's age becomes all ones (3 by default). In the same set, every other way with a nonzero age drops by one, and ages of 0 stay 0.
- R7: The probe port applies R1 to R4 to `probe_va_i` and `probe_we_i`. It returns 0 on a miss or on a rights failure, raises no strobe and changes no age. `probe_age_o` shows the age of the probed hitting way, or 0.
- R8: When several ways of a set hit, the highest-numbered way supplies the result.
- R9: Reset (`rst_ni` low) clears every valid flag and every age, so every lookup that follows misses.
- R10: `cfg_o[1:0]` is `NUM_WAYS-1` and `cfg_o[6:3]` is `log2(NUM_SETS)`. All other bits are 0.
- R11: A write with `wr_sel_i`=0 loads the tag half of the selected entry: tag from `wr_data_i[VA_W-1 -: TAG_W]`, valid from bit 0, age from bits `[LRU_W:1]`. A write with `wr_sel_i`=1 loads the attribute half: ppn from `wr_data_i[VA_W-1:PAGE_W]`, attributes from bits `[4:0]`. A tag-half write overrides a same-cycle age update of that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Qualifies the lookup for strobes and aging |
| va_i | input | VA_W | Virtual address |
| we_i | input | 1 | Access is a store |
| super_i | input | 1 | Supervisor mode |
| xlate_en_i | input | 1 | Translation enabled |
| mmu_present_i | input | 1 | Unit configured as present |
| pa_o | output | VA_W | Physical address |
| ci_o | output | 1 | Cache inhibit |
| hit_o | output | 1 | Lookup hit |
| page_fault_o | output | 1 | Access-rights fault pulse |
| tlb_miss_o | output | 1 | Miss pulse |
| wr_en_i | input | 1 | Entry write strobe |
| wr_sel_i | input | 1 | 0 tag half, 1 attribute half |
| wr_set_i | input | SET_W | Set written |
| wr_way_i | input | WAY_W | Way written |
| wr_data_i | input | VA_W | Entry write data |
| probe_va_i | input | VA_W | Debug lookup address |
| probe_we_i | input | 1 | Debug lookup checks write rights |
| probe_pa_o | output | VA_W | Debug lookup result |
| probe_age_o | output | LRU_W | Age of probed hitting way |
| cfg_o | output | 8 | Geometry word |

## Verification
The bench targets ages that sit at zero next to ages that are nonzero, because a design that wraps a zero age to all ones would show a large age on the probe port. It loads two ways of one set with the same tag, where a design that prefers the lowest way returns the wrong page number. It crosses mode and direction against single-bit attribute patterns, which exposes a swapped supervisor and user pair or a swapped read and write pair as a missing or spurious fault. It probes with rights that fail: a probe that leaked into aging, or that reported a rights failure as a translation, would show up as a changed age or a nonzero probe address.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

  typedef struct packed {
    logic uwe;
    logic ure;
    logic swe;
    logic sre;
    logic ci;
  } xlate_attr_t;

  localparam int unsigned ATTR_W = 5;

  typedef enum logic {
    SEL_MATCH = 1'b0,
    SEL_XLATE = 1'b1
  } wr_sel_e;

  function automatic logic access_ok(xlate_attr_t a, logic sup, logic wr);
    if (sup) return wr ? a.swe : a.sre;
    return wr ? a.uwe : a.ure;
  endfunction

endpackage

// File: rtl/dtlb_entry_store.sv
module dtlb_entry_store
  import dtlb_pkg::*;
#(
  parameter int unsigned NUM_SETS = 4,
  parameter int unsigned NUM_WAYS = 2,
  parameter int unsigned TAG_W    = 17,
  parameter int unsigned PPN_W    = 19,
  parameter int unsigned LRU_W    = 2,
  localparam int unsigned SET_W   = $clog2(NUM_SETS),
  localparam int unsigned WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [SET_W-1:0]  wr_set_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic              wr_valid_i,
  input  logic [LRU_W-1:0]  wr_lru_i,
  input  logic [PPN_W-1:0]  wr_ppn_i,
  input  xlate_attr_t       wr_attr_i,
  input  logic              upd_i,
  input  logic [SET_W-1:0]  upd_set_i,
  input  logic [WAY_W-1:0]  upd_way_i,
  input  logic [SET_W-1:0]  a_set_i,
  output logic [TAG_W-1:0]  a_tag_o   [NUM_WAYS],
  output logic              a_valid_o [NUM_WAYS],
  output logic [LRU_W-1:0]  a_lru_o   [NUM_WAYS],
  output logic [PPN_W-1:0]  a_ppn_o   [NUM_WAYS],
  output xlate_attr_t       a_attr_o  [NUM_WAYS],
  input  logic [SET_W-1:0]  b_set_i,
  output logic [TAG_W-1:0]  b_tag_o   [NUM_WAYS],
  output logic              b_valid_o [NUM_WAYS],
  output logic [LRU_W-1:0]  b_lru_o   [NUM_WAYS],
  output logic [PPN_W-1:0]  b_ppn_o   [NUM_WAYS],
  output xlate_attr_t       b_attr_o  [NUM_WAYS]
);

  localparam logic [LRU_W-1:0] LRU_MAX = {LRU_W{1'b1}};

  logic [TAG_W-1:0] tag_q   [NUM_SETS][NUM_WAYS];
  logic             valid_q [NUM_SETS][NUM_WAYS];
  logic [LRU_W-1:0] lru_q   [NUM_SETS][NUM_WAYS];
  logic [PPN_W-1:0] ppn_q   [NUM_SETS][NUM_WAYS];
  xlate_attr_t      attr_q  [NUM_SETS][NUM_WAYS];

  // valid and age: reset, aged by hits, overridden by tag-half writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          lru_q[s][w]   <= '0;
        end
    end else begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++) begin
          if (upd_i && upd_set_i == SET_W'(s)) begin
            if (upd_way_i == WAY_W'(w))   lru_q[s][w] <= LRU_MAX;
            else if (lru_q[s][w] != '0)   lru_q[s][w] <= lru_q[s][w] - 1'b1;
          end
          if (wr_en_i && wr_sel_i == SEL_MATCH &&
              wr_set_i == SET_W'(s) && wr_way_i == WAY_W'(w)) begin
            valid_q[s][w] <= wr_valid_i;
            lru_q[s][w]   <= wr_lru_i;
          end
        end
    end
  end

  // payload storage, no reset needed
  always_ff @(posedge clk_i) begin
    for (int s = 0; s < NUM_SETS; s++)
      for (int w = 0; w < NUM_WAYS; w++)
        if (wr_en_i && wr_set_i == SET_W'(s) && wr_way_i == WAY_W'(w)) begin
          if (wr_sel_i == SEL_MATCH) tag_q[s][w] <= wr_tag_i;
          else begin
            ppn_q[s][w]  <= wr_ppn_i;
            attr_q[s][w] <= wr_attr_i;
          end
        end
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rd
    assign a_tag_o[w]   = tag_q[a_set_i][w];
    assign a_valid_o[w] = valid_q[a_set_i][w];
    assign a_lru_o[w]   = lru_q[a_set_i][w];
    assign a_ppn_o[w]   = ppn_q[a_set_i][w];
    assign a_attr_o[w]  = attr_q[a_set_i][w];
    assign b_tag_o[w]   = tag_q[b_set_i][w];
    assign b_valid_o[w] = valid_q[b_set_i][w];
    assign b_lru_o[w]   = lru_q[b_set_i][w];
    assign b_ppn_o[w]   = ppn_q[b_set_i][w];
    assign b_attr_o[w]  = attr_q[b_set_i][w];
  end

  // check-only trace of the last aging request
  logic             chk_upd_q;
  logic [SET_W-1:0] chk_set_q;
  logic [WAY_W-1:0] chk_way_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_upd_q <= 1'b0;
      chk_set_q <= '0;
      chk_way_q <= '0;
    end else begin
      chk_upd_q <= upd_i && !(wr_en_i && wr_sel_i == SEL_MATCH &&
                              wr_set_i == upd_set_i && wr_way_i == upd_way_i);
      chk_set_q <= upd_set_i;
      chk_way_q <= upd_way_i;
    end
  end

  AST_HIT_AGE_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_upd_q |-> lru_q[chk_set_q][chk_way_q] == LRU_MAX); // R6

endmodule

// File: rtl/dtlb_way_match.sv
module dtlb_way_match
  import dtlb_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 2,
  parameter int unsigned TAG_W    = 17,
  parameter int unsigned PPN_W    = 19,
  parameter int unsigned LRU_W    = 2,
  localparam int unsigned WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic [TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0] tag_ways_i   [NUM_WAYS],
  input  logic             valid_ways_i [NUM_WAYS],
  input  logic [LRU_W-1:0] lru_ways_i   [NUM_WAYS],
  input  logic [PPN_W-1:0] ppn_ways_i   [NUM_WAYS],
  input  xlate_attr_t      attr_ways_i  [NUM_WAYS],
  output logic             hit_o,
  output logic [WAY_W-1:0] way_o,
  output logic [LRU_W-1:0] lru_o,
  output logic [PPN_W-1:0] ppn_o,
  output xlate_attr_t      attr_o
);

  logic [NUM_WAYS-1:0] way_hit;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign way_hit[w] = valid_ways_i[w] && (tag_ways_i[w] == tag_i);
  end

  // ascending scan: highest-numbered hit wins
  always_comb begin
    hit_o  = 1'b0;
    way_o  = '0;
    lru_o  = '0;
    ppn_o  = '0;
    attr_o = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (way_hit[w]) begin
        hit_o  = 1'b1;
        way_o  = WAY_W'(w);
        lru_o  = lru_ways_i[w];
        ppn_o  = ppn_ways_i[w];
        attr_o = attr_ways_i[w];
      end
    end
  end

endmodule

// File: rtl/dtlb_lookup.sv
module dtlb_lookup
  import dtlb_pkg::*;
#(
  parameter int unsigned VA_W       = 32,
  parameter int unsigned PAGE_BYTES = 8192,
  parameter int unsigned NUM_SETS   = 4,
  parameter int unsigned NUM_WAYS   = 2,
  parameter int unsigned LRU_W      = 2,
  localparam int unsigned PAGE_W    = $clog2(PAGE_BYTES),
  localparam int unsigned SET_W     = $clog2(NUM_SETS),
  localparam int unsigned WAY_W     = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int unsigned TAG_W     = VA_W - PAGE_W - SET_W,
  localparam int unsigned PPN_W     = VA_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic              we_i,
  input  logic              super_i,
  input  logic              xlate_en_i,
  input  logic              mmu_present_i,
  output logic [VA_W-1:0]   pa_o,
  output logic              ci_o,
  output logic              hit_o,
  output logic              page_fault_o,
  output logic              tlb_miss_o,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [SET_W-1:0]  wr_set_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [VA_W-1:0]   wr_data_i,
  input  logic [VA_W-1:0]   probe_va_i,
  input  logic              probe_we_i,
  output logic [VA_W-1:0]   probe_pa_o,
  output logic [LRU_W-1:0]  probe_age_o,
  output logic [7:0]        cfg_o
);

  logic active;
  assign active = xlate_en_i && mmu_present_i;

  // write data decode
  logic [TAG_W-1:0] wr_tag;
  logic [LRU_W-1:0] wr_lru;
  logic [PPN_W-1:0] wr_ppn;
  xlate_attr_t      wr_attr;
  logic             unused_wr;
  assign wr_tag    = wr_data_i[VA_W-1 -: TAG_W];
  assign wr_lru    = wr_data_i[1 +: LRU_W];
  assign wr_ppn    = wr_data_i[VA_W-1 -: PPN_W];
  assign wr_attr   = xlate_attr_t'(wr_data_i[ATTR_W-1:0]);
  assign unused_wr = ^wr_data_i[PAGE_W-1:ATTR_W];

  logic [SET_W-1:0] l_set, p_set;
  logic [TAG_W-1:0] l_tag, p_tag;
  assign l_set = va_i[PAGE_W +: SET_W];
  assign l_tag = va_i[VA_W-1 -: TAG_W];
  assign p_set = probe_va_i[PAGE_W +: SET_W];
  assign p_tag = probe_va_i[VA_W-1 -: TAG_W];

  logic [TAG_W-1:0] a_tag [NUM_WAYS], b_tag [NUM_WAYS];
  logic             a_vld [NUM_WAYS], b_vld [NUM_WAYS];
  logic [LRU_W-1:0] a_lru [NUM_WAYS], b_lru [NUM_WAYS];
  logic [PPN_W-1:0] a_ppn [NUM_WAYS], b_ppn [NUM_WAYS];
  xlate_attr_t      a_att [NUM_WAYS], b_att [NUM_WAYS];

  logic             l_hit, p_hit, upd;
  logic [WAY_W-1:0] l_way, p_way;
  logic [LRU_W-1:0] l_age, p_age;
  logic [PPN_W-1:0] l_ppn, p_ppn;
  xlate_attr_t      l_att, p_att;

  dtlb_entry_store #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W),
    .PPN_W(PPN_W), .LRU_W(LRU_W)
  ) i_store (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_sel_i, .wr_set_i, .wr_way_i,
    .wr_tag_i(wr_tag), .wr_valid_i(wr_data_i[0]), .wr_lru_i(wr_lru),
    .wr_ppn_i(wr_ppn), .wr_attr_i(wr_attr),
    .upd_i(upd), .upd_set_i(l_set), .upd_way_i(l_way),
    .a_set_i(l_set), .a_tag_o(a_tag), .a_valid_o(a_vld), .a_lru_o(a_lru),
    .a_ppn_o(a_ppn), .a_attr_o(a_att),
    .b_set_i(p_set), .b_tag_o(b_tag), .b_valid_o(b_vld), .b_lru_o(b_lru),
    .b_ppn_o(b_ppn), .b_attr_o(b_att)
  );

  dtlb_way_match #(
    .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W), .LRU_W(LRU_W)
  ) i_match_req (
    .tag_i(l_tag), .tag_ways_i(a_tag), .valid_ways_i(a_vld),
    .lru_ways_i(a_lru), .ppn_ways_i(a_ppn), .attr_ways_i(a_att),
    .hit_o(l_hit), .way_o(l_way), .lru_o(l_age), .ppn_o(l_ppn), .attr_o(l_att)
  );

  dtlb_way_match #(
    .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W), .LRU_W(LRU_W)
  ) i_match_probe (
    .tag_i(p_tag), .tag_ways_i(b_tag), .valid_ways_i(b_vld),
    .lru_ways_i(b_lru), .ppn_ways_i(b_ppn), .attr_ways_i(b_att),
    .hit_o(p_hit), .way_o(p_way), .lru_o(p_age), .ppn_o(p_ppn), .attr_o(p_att)
  );

  logic l_ok, p_ok, unused_pway;
  assign l_ok        = access_ok(l_att, super_i, we_i);
  assign p_ok        = access_ok(p_att, super_i, probe_we_i);
  assign unused_pway = ^p_way;

  // request path
  always_comb begin
    if (!active) begin
      pa_o = va_i;
      ci_o = va_i[VA_W-1];
    end else if (l_hit) begin
      pa_o = {l_ppn, va_i[PAGE_W-1:0]};
      ci_o = l_att.ci;
    end else begin
      pa_o = '0;
      ci_o = 1'b0;
    end
  end

  assign hit_o        = active && l_hit;
  assign page_fault_o = req_valid_i && active && l_hit && !l_ok;
  assign tlb_miss_o   = req_valid_i && active && !l_hit;
  assign upd          = req_valid_i && active && l_hit;

  // debug probe path: no strobes, no aging
  always_comb begin
    if (!active)             probe_pa_o = probe_va_i;
    else if (p_hit && p_ok)  probe_pa_o = {p_ppn, probe_va_i[PAGE_W-1:0]};
    else                     probe_pa_o = '0;
  end
  assign probe_age_o = (active && p_hit) ? p_age : '0;

  assign cfg_o = 8'((SET_W << 3) | (NUM_WAYS - 1));

  AST_MISS_PA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_miss_o |-> (pa_o == '0 && !hit_o && !ci_o)); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(page_fault_o && tlb_miss_o)); // R4
  AST_STROBE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!page_fault_o && !tlb_miss_o)); // R5
  AST_BYPASS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xlate_en_i && mmu_present_i) |-> (!hit_o && !page_fault_o && !tlb_miss_o
                                         && pa_o == va_i)); // R1
  AST_HIT_KEEPS_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> pa_o[PAGE_W-1:0] == va_i[PAGE_W-1:0]); // R3
  AST_AGE_HELD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i && !wr_en_i && $past(!req_valid_i && !wr_en_i) &&
     $stable(probe_va_i) && $stable(xlate_en_i) && $stable(mmu_present_i))
    |-> $stable(probe_age_o)); // R7

endmodule

// File: tb/test_dtlb_lookup.sv
`timescale 1ns/1ps
module test_dtlb_lookup;

  localparam int VA_W = 32, PAGE_W = 13, SET_W = 2, NSETS = 4, NWAYS = 2;
  localparam int TAG_W = VA_W - PAGE_W - SET_W, PPN_W = VA_W - PAGE_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, we = 0, sup = 0, en = 0, pres = 0;
  logic [31:0] va = '0, wr_data = '0, pva = '0;
  logic wr_en = 0, wr_sel = 0, pwe = 0;
  logic [1:0] wr_set = '0;
  logic [0:0] wr_way = '0;
  logic [31:0] pa, ppa;
  logic ci, hit, pf, miss;
  logic [1:0] page;
  logic [7:0] cfg;

  always #10 clk = ~clk;

  dtlb_lookup i_dtlb_lookup (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .va_i(va), .we_i(we),
    .super_i(sup), .xlate_en_i(en), .mmu_present_i(pres), .pa_o(pa), .ci_o(ci),
    .hit_o(hit), .page_fault_o(pf), .tlb_miss_o(miss), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_set_i(wr_set), .wr_way_i(wr_way), .wr_data_i(wr_data),
    .probe_va_i(pva), .probe_we_i(pwe), .probe_pa_o(ppa), .probe_age_o(page),
    .cfg_o(cfg)
  );

  // reference model
  logic [TAG_W-1:0] m_tag [NSETS][NWAYS];
  logic             m_val [NSETS][NWAYS];
  logic [1:0]       m_age [NSETS][NWAYS];
  logic [PPN_W-1:0] m_ppn [NSETS][NWAYS];
  logic [4:0]       m_att [NSETS][NWAYS];

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  function automatic int find_way(logic [31:0] a);
    int hw = -1;
    int s = int'(a[PAGE_W +: SET_W]);
    for (int w = 0; w < NWAYS; w++)
      if (m_val[s][w] && m_tag[s][w] == a[31 -: TAG_W]) hw = w;
    return hw;
  endfunction

  function automatic logic rights(logic [4:0] at, logic s, logic w);
    return s ? (w ? at[2] : at[1]) : (w ? at[4] : at[3]);
  endfunction

  task automatic write_entry(int s, int w, logic sel, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_set = 2'(s); wr_way = 1'(w); wr_data = d;
    req_valid = 0;
    @(posedge clk); #1;
    if (!sel) begin
      m_tag[s][w] = d[31 -: TAG_W]; m_val[s][w] = d[0]; m_age[s][w] = d[2:1];
    end else begin
      m_ppn[s][w] = d[31 -: PPN_W]; m_att[s][w] = d[4:0];
    end
    wr_en = 0;
  endtask

  task automatic lookup(logic [31:0] a, logic w, logic s, logic e, logic p,
                        logic rq, logic [31:0] pa_in, logic pw);
    int hw, ph, st;
    logic act, ok;
    logic [31:0] e_pa, e_ppa;
    logic e_ci;
    string r;
    @(negedge clk);
    va = a; we = w; sup = s; en = e; pres = p; req_valid = rq; pva = pa_in; pwe = pw;
    #5;
    act = e & p;
    hw = find_way(a); ph = find_way(pa_in); st = int'(a[PAGE_W +: SET_W]);
    if (!act) begin e_pa = a; e_ci = a[31]; r = "R1"; end
    else if (hw >= 0) begin
      e_pa = {m_ppn[st][hw], a[PAGE_W-1:0]}; e_ci = m_att[st][hw][0]; r = "R3";
    end else begin e_pa = '0; e_ci = 0; r = "R5"; end
    ok = (hw >= 0) ? rights(m_att[st][hw], s, w) : 1'b0;
    chk(r, "pa", pa, e_pa);
    chk(r, "ci", 32'(ci), 32'(e_ci));
    chk("R2", "hit", 32'(hit), 32'(act && hw >= 0));
    chk("R4", "page_fault", 32'(pf), 32'(rq && act && hw >= 0 && !ok));
    chk("R5", "tlb_miss", 32'(miss), 32'(rq && act && hw < 0));
    if (!act) e_ppa = pa_in;
    else if (ph >= 0 && rights(m_att[pa_in[PAGE_W +: SET_W]][ph], s, pw))
      e_ppa = {m_ppn[pa_in[PAGE_W +: SET_W]][ph], pa_in[PAGE_W-1:0]};
    else e_ppa = '0;
    chk("R7", "probe_pa", ppa, e_ppa);
    chk("R7", "probe_age", 32'(page),
        32'((act && ph >= 0) ? m_age[pa_in[PAGE_W +: SET_W]][ph] : 2'd0));
    @(posedge clk); #1;
    if (rq && act && hw >= 0) begin
      for (int k = 0; k < NWAYS; k++)
        if (k == hw) m_age[st][k] = 2'd3;
        else if (m_age[st][k] != 0) m_age[st][k] = m_age[st][k] - 1;
    end
    req_valid = 0;
  endtask

  function automatic logic [31:0] mk_va(logic [TAG_W-1:0] t, int s, logic [12:0] off);
    return {t, 2'(s), off};
  endfunction

  function automatic logic [TAG_W-1:0] pool(int i);
    return TAG_W'(17'h0A5C3 + i * 17'h1111);
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int s = 0; s < NSETS; s++)
      for (int w = 0; w < NWAYS; w++) begin
        m_val[s][w] = 0; m_age[s][w] = 0; m_tag[s][w] = '0; m_ppn[s][w] = '0; m_att[s][w] = '0;
      end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R10 geometry word
    chk("R10", "cfg", 32'(cfg), 32'h11);
    // R9 reset: all lookups miss
    lookup(mk_va(pool(0), 1, 13'h10), 0, 1, 1, 1, 1, mk_va(pool(0), 1, 0), 0);
    chk("R9", "miss after reset", 32'(miss), 32'h1);
    // R1 bypass, both sides of the ci threshold
    lookup(32'h7FFF_FFFF, 0, 0, 0, 1, 1, 32'h8000_0000, 0);
    lookup(32'h8000_0000, 1, 1, 1, 0, 1, 32'h1234_5678, 1);

    // R11 load entry, R3 translate
    write_entry(1, 0, 0, mk_va(pool(0), 0, 13'h0) | 32'h1);
    write_entry(1, 0, 1, {19'h5ABCD, 13'h01F});
    lookup(mk_va(pool(0), 1, 13'h1A3), 0, 1, 1, 1, 1, mk_va(pool(0), 1, 13'h7), 1);
    // R2 same tag, other set misses
    lookup(mk_va(pool(0), 2, 13'h1A3), 0, 1, 1, 1, 1, mk_va(pool(0), 2, 0), 0);
    // R4 rights: each single-bit attribute against mode and direction
    for (int b = 1; b <= 4; b++) begin
      write_entry(1, 0, 1, {19'h00777, 8'h0, 5'(1 << b)});
      for (int m = 0; m < 4; m++)
        lookup(mk_va(pool(0), 1, 13'h2), m[1], m[0], 1, 1, 1,
               mk_va(pool(0), 1, 13'h3), ~m[1]);
    end

    // R8 two ways, same tag: way 1 wins
    write_entry(3, 0, 0, mk_va(pool(1), 0, 0) | 32'h1);
    write_entry(3, 0, 1, {19'h11111, 13'h1E});
    write_entry(3, 1, 0, mk_va(pool(1), 0, 0) | 32'h1);
    write_entry(3, 1, 1, {19'h22222, 13'h1E});
    lookup(mk_va(pool(1), 3, 13'h55), 0, 0, 1, 1, 1, mk_va(pool(1), 3, 0), 0);
    chk("R8", "highest way ppn", pa, {19'h22222, 13'h55});

    // R6 aging: way0 age 2, way1 age 0 under a different tag
    write_entry(2, 0, 0, mk_va(pool(2), 0, 0) | 32'h5);
    write_entry(2, 0, 1, {19'h33333, 13'h1E});
    write_entry(2, 1, 0, mk_va(pool(3), 0, 0) | 32'h1);
    write_entry(2, 1, 1, {19'h44444, 13'h1E});
    lookup(mk_va(pool(2), 2, 0), 0, 0, 1, 1, 1, mk_va(pool(3), 2, 0), 0);
    lookup(mk_va(pool(3), 2, 0), 0, 0, 1, 1, 1, mk_va(pool(2), 2, 0), 0);
    chk("R6", "way0 aged", 32'(page), 32'h2);
    lookup(mk_va(pool(3), 2, 0), 0, 0, 1, 1, 1, mk_va(pool(3), 2, 0), 0);
    chk("R6", "way1 max", 32'(page), 32'h3);
    // R7 probe only, failing rights: no aging, result 0
    write_entry(2, 0, 1, {19'h33333, 13'h00});
    lookup(mk_va(pool(2), 2, 0), 0, 0, 1, 1, 0, mk_va(pool(2), 2, 0), 1);
    lookup(mk_va(pool(2), 2, 0), 0, 0, 1, 1, 0, mk_va(pool(2), 2, 0), 0);
    chk("R7", "probe age unchanged", 32'(page), 32'h1);
    chk("R7", "probe denied", ppa, 32'h0);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int s = int'($urandom_range(NSETS - 1));
      int w = int'($urandom_range(NWAYS - 1));
      logic [TAG_W-1:0] t = pool(int'($urandom_range(3)));
      logic [TAG_W-1:0] tp = pool(int'($urandom_range(3)));
      if ($urandom_range(9) < 3) begin
        if ($urandom_range(1) == 0)
          write_entry(s, w, 0, {t, 2'b0, 10'h0, 2'($urandom), ($urandom_range(3) != 0)});
        else
          write_entry(s, w, 1, {19'($urandom), 8'h0, 5'($urandom)});
      end else begin
        lookup(mk_va(t, s, 13'($urandom)), 1'($urandom), 1'($urandom),
               ($urandom_range(7) != 0), ($urandom_range(7) != 0), ($urandom_range(3) != 0),
               mk_va(tp, int'($urandom_range(NSETS - 1)), 13'($urandom)), 1'($urandom));
      end
    end

    // R9 reset again clears everything
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int s = 0; s < NSETS; s++)
      for (int w = 0; w < NWAYS; w++) begin m_val[s][w] = 0; m_age[s][w] = 0; end
    lookup(mk_va(pool(1), 3, 13'h55), 0, 0, 1, 1, 1, mk_va(pool(1), 3, 0), 0);
    chk("R9", "miss after second reset", 32'(miss), 32'h1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule